// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block is the transmit half of a half-duplex synchronous serial port working as clock master. It drives a shift clock and a serial data line, and each line has its own output enable so that the pad can be tri-stated. Software writes a word into a one-entry holding buffer. The block moves the word into an internal shift register when that register is free. It then sends the word out one bit per shift-clock period, with the least significant bit first.

A free-running divider counts down from a programmable reload value. Its pulses toggle the shift clock, so one clock period is 2 × (reload + 1) system cycles. The divider is held in reset while every port enable is clear. A receive request, either continuous or single-word, suspends the transmitter and frees the data line. The transmitter keeps its state while suspended. Clearing the transmit enable resets the transmitter completely, but the holding buffer keeps its contents. A ninth data bit can be appended in 9-bit mode.

Top module: `sync_serial_tx`

## Requirements
- R1: After reset, `buf_empty` and `shreg_empty` are 1, and `sck_out`, `sck_oe` and `sdo_oe` are 0.
- R2: `buf_empty` goes low only on a write (`wr_valid`). Software has no way to set it high. While `tx_en` is 0, a written word stays in the buffer, `buf_empty` stays 0, and neither output enable is asserted.
- R3: When `tx_en` is 1, no receive is active and the shift register is idle, a write at edge N makes `buf_empty` 0 after edge N. The transfer happens at edge N+1, after which `buf_empty` is 1 again and `shreg_empty` is 0.
- R4: Bits leave least significant bit first. Each bit appears on `sdo_out` at the same edge at which `sck_out` rises. It stays unchanged until the next rise. `sck_out` is 0 between words.
- R5: With `nine_mode` = 1, a ninth bit follows the 8 data bits. Its value is `ninth_bit` as sampled at the transfer edge, and later changes to `ninth_bit` do not affect it. With `nine_mode` = 0, exactly 8 bits are sent.
- R6: Successive rising edges of `sck_out` within a word are 2 × (`div_reload` + 1) clock cycles apart.
- R7: A word that is waiting in the buffer is sent directly after the previous one. The interval between the last rise of one word and the first rise of the next equals the normal bit period.
- R8: `shreg_empty` is 0 from the transfer edge until the falling clock edge that follows the last bit. `sck_out` rises only while a word is in the shift register.
- R9: Clearing `tx_en` during a word aborts it. On the next cycle, `sck_oe` and `sdo_oe` are 0, `sck_out` is 0 and `shreg_empty` is 1. A word held in the buffer survives and is sent after `tx_en` is set again.
- R10: While `rx_cont_en` is 1 or a single receive is active, `sdo_oe` is 0, `sck_oe` stays 1, and the transmitter is frozen: there are no clock rises and no bit is lost. On release, the word resumes where it stopped.
- R11: A pulse on `rx_single_req` sets `rx_single_act`. A pulse on `rx_word_done` clears it, and if `tx_en` is still 1, `sdo_oe` is 1 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable; clearing it resets the transmitter |
| rx_cont_en | input | 1 | Continuous receive enable; suspends transmit |
| rx_single_req | input | 1 | Pulse: start a single-word receive |
| rx_word_done | input | 1 | Pulse: the single-word receive has completed |
| nine_mode | input | 1 | 1 = append a ninth bit to each word |
| ninth_bit | input | 1 | Value of the ninth bit, sampled at transfer |
| div_reload | input | DIV_W | Divider reload value |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Word to transmit |
| sck_out | output | 1 | Shift clock level |
| sck_oe | output | 1 | Shift clock output enable |
| sdo_out | output | 1 | Serial data level |
| sdo_oe | output | 1 | Serial data output enable |
| buf_empty | output | 1 | Holding buffer is free |
| shreg_empty | output | 1 | Shift register holds no word |
| rx_single_act | output | 1 | A single-word receive is in progress |

## Verification
The embedded assertions check the following on every cycle:
- the buffer flag falls only after a write;
- an idle shift register takes a waiting word on the next edge;
- the data line holds steady while the clock is high;
- the clock never rises while transmit is suspended or with no word present;
- a cleared transmit enable leaves the transmitter empty;
- divider pulses never come back to back when the reload is nonzero.

Bit order, the ninth-bit sampling instant, the exact bit period for each reload value, gapless back-to-back words, survival of the buffered word across an abort, and resumption after a suspension can only be shown by the bench's scenarios, which reconstruct every word from the pins.

// File: rtl/sstx_pkg.sv
// Package: shared defaults for the synchronous serial transmitter.
// Assumes: consumers take these as parameter defaults only.
package sstx_pkg;
    localparam int SSTX_DATA_W = 8;   // data bits per word, excluding the ninth
    localparam int SSTX_DIV_W  = 8;   // width of the divider reload value
endpackage

// File: rtl/sstx_clkdiv.sv
// Module: sstx_clkdiv
// Down-counter that emits a one-cycle tick each time it reaches zero and
// then reloads. Held at zero while run is low, so the first tick comes
// in the first cycle that run is high.
// Assumes: reload may change at any time and takes effect at the next tick.
module sstx_clkdiv #(
    parameter int DIV_W = sstx_pkg::SSTX_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    // Count down; reload on tick; hold in reset while the port is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R6: a nonzero, unchanged reload spaces ticks at least two cycles apart.
    p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reload != '0) |=> !tick);
endmodule

// File: rtl/sstx_txbuf.sv
// Module: sstx_txbuf
// One-entry holding buffer. A write fills it, overwriting any older word.
// A take empties it. A write in the same cycle as a take wins.
// Assumes: take is only asserted while the buffer is full.
module sstx_txbuf #(
    parameter int DATA_W = sstx_pkg::SSTX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] buf_data,
    output logic              buf_full
);
    // Capture written data; the full flag clears only on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_data <= '0;
            buf_full <= 1'b0;
        end else if (wr_valid) begin
            buf_data <= wr_data;
            buf_full <= 1'b1;
        end else if (take) begin
            buf_full <= 1'b0;
        end
    end

    // R2: the buffer only becomes full after a write.
    p_fill_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full) |-> $past(wr_valid));
endmodule

// File: rtl/sstx_shifter.sv
// Module: sstx_shifter
// Shift engine. Each divider tick toggles the shift clock. A rising clock
// launches the next bit, least significant bit first. The falling clock
// after the last bit ends the word, and a waiting word is loaded at that
// same edge. hold freezes everything. A low tx_en clears everything.
// Assumes: tick comes from a divider that runs whenever tx_en is high.
module sstx_shifter #(
    parameter int DATA_W = sstx_pkg::SSTX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              hold,
    input  logic              tick,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              nine_mode,
    input  logic              ninth_bit,
    output logic              take,
    output logic              sck,
    output logic              sdo,
    output logic              sh_empty
);
    localparam int CNT_W = $clog2(DATA_W + 2);

    logic [DATA_W:0]    sh_q;
    logic [CNT_W-1:0]   left_q;
    logic               step, word_end, idle;

    assign step     = tick && tx_en && !hold;
    assign idle     = !sck && (left_q == '0);
    assign word_end = step && sck && (left_q == '0);
    assign take     = tx_en && !hold && buf_full && (idle || word_end);
    assign sh_empty = idle;

    // Toggle the clock, launch bits on rising ticks, load a new word on take.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            sh_q   <= '0;
            left_q <= '0;
            sck    <= 1'b0;
            sdo    <= 1'b0;
        end else begin
            if (step && sck) begin
                sck <= 1'b0;
            end else if (step && left_q != '0) begin
                sck    <= 1'b1;
                sdo    <= sh_q[0];
                sh_q   <= {1'b0, sh_q[DATA_W:1]};
                left_q <= left_q - 1'b1;
            end
            if (take) begin
                sh_q   <= {nine_mode & ninth_bit, buf_data};
                left_q <= nine_mode ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);
            end
        end
    end

    // R4: data holds while the clock stays high.
    p_data_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdo));
    // R9: a cleared enable leaves the engine empty with the clock low.
    p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_en) |-> (sh_empty && !sck));
    // R10: while held, the engine does not move.
    p_hold_freezes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold) && $past(tx_en) && tx_en) |-> ($stable(sck) && $stable(left_q)));
endmodule

// File: rtl/sync_serial_tx.sv
// Module: sync_serial_tx (top)
// Half-duplex synchronous master transmitter: holding buffer, shift
// engine, shift-clock divider and the single-word receive hook.
// Assumes: receive data capture lives outside; rx_word_done marks the end
// of a single-word receive.
module sync_serial_tx #(
    parameter int DATA_W = sstx_pkg::SSTX_DATA_W,
    parameter int DIV_W  = sstx_pkg::SSTX_DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_cont_en,
    input  logic              rx_single_req,
    input  logic              rx_word_done,
    input  logic              nine_mode,
    input  logic              ninth_bit,
    input  logic [DIV_W-1:0]  div_reload,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic              buf_empty,
    output logic              shreg_empty,
    output logic              rx_single_act
);
    logic              suspend, run, tick, take, buf_full;
    logic [DATA_W-1:0] buf_data;

    assign suspend   = rx_cont_en || rx_single_act;
    assign run       = tx_en || suspend;
    assign sck_oe    = run;
    assign sdo_oe    = tx_en && !suspend;
    assign buf_empty = !buf_full;

    // Single-word receive request: set by request, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_single_act <= 1'b0;
        end else if (rx_single_req) begin
            rx_single_act <= 1'b1;
        end else if (rx_word_done) begin
            rx_single_act <= 1'b0;
        end
    end

    sstx_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .reload (div_reload),
        .tick   (tick)
    );

    sstx_txbuf #(.DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .buf_data (buf_data),
        .buf_full (buf_full)
    );

    sstx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .hold      (suspend),
        .tick      (tick),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .nine_mode (nine_mode),
        .ninth_bit (ninth_bit),
        .take      (take),
        .sck       (sck_out),
        .sdo       (sdo_out),
        .sh_empty  (shreg_empty)
    );

    // R3: an idle, enabled engine empties a full buffer on the next edge.
    p_transfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shreg_empty && !buf_empty && tx_en && !suspend) |=> (buf_empty || $past(wr_valid)));
    // R8: the clock only rises while a word is loaded.
    p_rise_needs_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_out) |-> !$past(shreg_empty));
    // R10: no clock rise while a receive holds the port.
    p_no_rise_suspended_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_out) |-> !$past(suspend));
endmodule

// File: tb/sync_serial_tx_tb.sv
// Bench for sync_serial_tx. Words are reconstructed from the pins and
// compared with arithmetic expectations.
module sync_serial_tx_tb;
    localparam int CLK_P = 10;
    localparam int DW    = 8;
    localparam int VW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0, rx_cont_en = 1'b0, rx_single_req = 1'b0, rx_word_done = 1'b0;
    logic          nine_mode = 1'b0, ninth_bit = 1'b0, wr_valid = 1'b0;
    logic [VW-1:0] div_reload = '0;
    logic [DW-1:0] wr_data = '0;
    logic          sck_out, sck_oe, sdo_out, sdo_oe, buf_empty, shreg_empty, rx_single_act;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cap_n = 0;
    logic cap_bits [0:63];
    int   cap_cyc  [0:63];
    logic sck_prev = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sync_serial_tx #(.DATA_W(DW), .DIV_W(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_cont_en(rx_cont_en),
        .rx_single_req(rx_single_req), .rx_word_done(rx_word_done),
        .nine_mode(nine_mode), .ninth_bit(ninth_bit), .div_reload(div_reload),
        .wr_valid(wr_valid), .wr_data(wr_data), .sck_out(sck_out), .sck_oe(sck_oe),
        .sdo_out(sdo_out), .sdo_oe(sdo_oe), .buf_empty(buf_empty),
        .shreg_empty(shreg_empty), .rx_single_act(rx_single_act)
    );

    // Pin monitor: record the data bit and cycle at each clock rise.
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        if (sck_out && !sck_prev && cap_n < 64) begin
            cap_bits[cap_n] = sdo_out;
            cap_cyc[cap_n]  = cyc;
            cap_n = cap_n + 1;
        end
        sck_prev = sck_out;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [DW-1:0] d);
        @(negedge clk);
        wr_data  = d;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (shreg_empty && buf_empty) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_bits(input int n);
        for (int i = 0; i < 5000; i++) begin
            if (cap_n >= n) break;
            @(negedge clk);
        end
    endtask

    // Compare captured bits with an expected vector; optionally the spacing.
    task automatic check_word(input int nb, input logic [63:0] exp, input int rel,
                              input logic do_per, input string tag);
        logic [63:0] act = '0;
        int bad = 0;
        for (int i = 0; i < cap_n; i++) act[i] = cap_bits[i];
        chk(cap_n == nb && act == exp, tag, int'(act[31:0]) + cap_n * 0, int'(exp[31:0]));
        if (cap_n != nb) chk(1'b0, {tag, " count"}, cap_n, nb);
        if (do_per) begin
            for (int k = 1; k < cap_n; k++)
                if (cap_cyc[k] - cap_cyc[k-1] != 2 * (rel + 1)) bad++;
            chk(bad == 0, {tag, " R6 period"}, bad, 0);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(buf_empty && shreg_empty && !sck_out && !sck_oe && !sdo_oe, "R1 reset",
            {buf_empty, shreg_empty, sck_out, sck_oe, sdo_oe}, 5'b11000);
        rst_n = 1'b1;

        // R2: disabled transmitter keeps the word and drives nothing
        div_reload = 8'd1;
        write_word(8'hA5);
        repeat (10) @(negedge clk);
        chk(!buf_empty && !sck_oe && !sdo_oe, "R2 held while disabled",
            {buf_empty, sck_oe, sdo_oe}, 0);
        cap_n = 0;
        tx_en = 1'b1;
        @(negedge clk);
        wait_idle();
        check_word(8, 64'hA5, 1, 1'b1, "R2 R4 sent after enable");

        // R3: transfer timing from an idle engine
        repeat (4) @(negedge clk);
        cap_n = 0;
        wr_data = 8'h3C;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(!buf_empty && shreg_empty, "R3 after write", {buf_empty, shreg_empty}, 2'b01);
        @(negedge clk);
        chk(buf_empty && !shreg_empty, "R3 R8 after transfer", {buf_empty, shreg_empty}, 2'b10);
        wait_bits(8);
        chk(!shreg_empty, "R8 busy until final fall", shreg_empty, 0);
        wait_idle();
        chk(!sck_out, "R4 clock idles low", sck_out, 0);
        check_word(8, 64'h3C, 1, 1'b1, "R4 word 3C");

        // Sweep: reload values, 8/9-bit, data patterns
        for (int r = 0; r < 3; r++) begin
            for (int m = 0; m < 2; m++) begin
                for (int p = 0; p < 6; p++) begin
                    @(negedge clk);
                    div_reload = VW'((r == 2) ? 3 : r);
                    nine_mode  = m[0];
                    ninth_bit  = p[0];
                    d = DW'((p * 83 + r * 29 + 1) % 256);
                    repeat (2) @(negedge clk);
                    cap_n = 0;
                    write_word(d);
                    wait_idle();
                    check_word(m ? 9 : 8, m ? {55'd0, p[0], d} : {56'd0, d},
                               (r == 2) ? 3 : r, 1'b1, m ? "R5 sweep 9-bit" : "R4 sweep 8-bit");
                end
            end
        end

        // R5: ninth bit sampled at transfer, later change ignored
        @(negedge clk);
        div_reload = 8'd2;
        nine_mode = 1'b1;
        ninth_bit = 1'b1;
        cap_n = 0;
        write_word(8'h81);
        @(negedge clk);
        ninth_bit = 1'b0;
        wait_idle();
        check_word(9, {55'd0, 1'b1, 8'h81}, 2, 1'b1, "R5 late ninth change");
        nine_mode = 1'b0;

        // R7: back-to-back words with no gap
        repeat (3) @(negedge clk);
        cap_n = 0;
        write_word(8'h6B);
        @(negedge clk);
        write_word(8'hD2);
        wait_idle();
        check_word(16, {48'd0, 8'hD2, 8'h6B}, 2, 1'b1, "R7 back to back");

        // R9: abort mid-word, buffered word survives
        div_reload = 8'd1;
        repeat (3) @(negedge clk);
        cap_n = 0;
        write_word(8'hF0);
        @(negedge clk);
        write_word(8'h5A);
        wait_bits(3);
        tx_en = 1'b0;
        @(negedge clk);
        chk(!sck_oe && !sdo_oe && !sck_out && shreg_empty && !buf_empty, "R9 abort state",
            {sck_oe, sdo_oe, sck_out, shreg_empty, buf_empty}, 5'b00010);
        cap_n = 0;
        tx_en = 1'b1;
        @(negedge clk);
        wait_idle();
        check_word(8, 64'h5A, 1, 1'b1, "R9 buffered word after abort");

        // R10: continuous receive suspends and resumes
        repeat (3) @(negedge clk);
        cap_n = 0;
        write_word(8'hC3);
        wait_bits(4);
        rx_cont_en = 1'b1;
        @(negedge clk);
        chk(!sdo_oe && sck_oe, "R10 lines during receive", {sdo_oe, sck_oe}, 2'b01);
        d = DW'(cap_n);
        repeat (20) @(negedge clk);
        chk(cap_n == int'(d) && !shreg_empty, "R10 frozen", cap_n, int'(d));
        rx_cont_en = 1'b0;
        wait_idle();
        check_word(8, 64'hC3, 1, 1'b0, "R10 resumed word");

        // R11: single-word receive hook
        repeat (3) @(negedge clk);
        cap_n = 0;
        write_word(8'h99);
        wait_bits(2);
        rx_single_req = 1'b1;
        @(negedge clk);
        rx_single_req = 1'b0;
        chk(rx_single_act && !sdo_oe && sck_oe, "R11 single active",
            {rx_single_act, sdo_oe, sck_oe}, 3'b101);
        repeat (10) @(negedge clk);
        rx_word_done = 1'b1;
        @(negedge clk);
        rx_word_done = 1'b0;
        chk(!rx_single_act && sdo_oe, "R11 data line returns", {rx_single_act, sdo_oe}, 2'b01);
        wait_idle();
        check_word(8, 64'h99, 1, 1'b0, "R11 word intact");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule